// File: doc/BRIEF.md
# Free-Running Video Sync Timing Generator

This block produces the vertical sync, horizontal sync and data-enable waveforms of a video stream from a single pixel clock. Each waveform has its own interval counters. Software writes every duration and offset as a raw number of pixel clocks. The vertical pulse defines the frame. The horizontal and data-enable trains each start a programmed number of clocks after the vertical pulse begins. They then alternate between an active interval and an idle interval for a programmed number of repetitions.

The block also gives a downstream pattern source two strobes. The frame strobe marks the first cycle of every frame. The line strobe marks the first cycle of every data-enable pulse. Timing inputs are copied into shadow registers when a frame begins, so changes written mid-frame take effect from the next frame. The start delay is used once, when the generator is enabled. Separate controls invert the polarity of the horizontal and vertical sync outputs.

Top module: `sync_timing_gen`

## Requirements
- R1: After the first clock edge at which `en` is sampled high (with `rst` low), the first frame strobe and vertical pulse appear exactly `start_delay` cycles later. A delay of 0 starts the frame on that same edge. The delay is applied only once per enable.
- R2: Each frame starts with the vertical sync active for `vs_on_len` cycles, then inactive for `vs_off_len` cycles. The next frame then begins at once. A length of 0 counts as 1. `frame_start_o` is high for exactly the first cycle of each frame.
- R3: The first horizontal pulse goes active `hs_offset` cycles after the first cycle of the frame. Each pulse is active for `hs_on_len` cycles and then inactive for `hs_off_len` cycles, for `hs_pulses` pulses. A length of 0 counts as 1.
- R4: Data enable follows the same rule as R3, using `de_offset`, `de_on_len`, `de_off_len` and `de_pulses`.
- R5: After its last pulse, a train stays inactive until the next frame. A new frame restarts both trains at once, cutting short any pulse or interval still in progress.
- R6: A pulse count of 0 produces no pulses in that frame.
- R7: `line_start_o` is high for exactly the first cycle of each data-enable pulse.
- R8: All lengths, offsets and counts are sampled on the edge that starts a frame. Changes made during a frame do not affect that frame. `start_delay` is sampled only on the enabling edge.
- R9: `vs_o` and `hs_o` are the internal active levels XOR-ed with `vs_invert` and `hs_invert`, as sampled on the previous clock edge. `de_o` is never inverted.
- R10: A clock edge with `rst` high or `en` low clears every counter. From the next cycle, de_o, frame_start_o and line_start_o are 0 and vs_o/hs_o sit at their inverted-inactive level. Re-enabling then starts again with the R1 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the generator idle |
| start_delay | input | 24 | Clocks from enable to first frame |
| vs_on_len | input | 24 | Vertical sync active length |
| vs_off_len | input | 24 | Vertical sync inactive length |
| hs_offset | input | 24 | Frame start to first horizontal pulse |
| hs_on_len | input | 16 | Horizontal pulse active length |
| hs_off_len | input | 16 | Horizontal pulse inactive length |
| hs_pulses | input | 16 | Horizontal pulses per frame |
| de_offset | input | 24 | Frame start to first data-enable pulse |
| de_on_len | input | 16 | Data-enable active length |
| de_off_len | input | 16 | Data-enable inactive length |
| de_pulses | input | 16 | Data-enable pulses per frame |
| hs_invert | input | 1 | Invert horizontal sync output |
| vs_invert | input | 1 | Invert vertical sync output |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | First cycle of each frame |
| line_start_o | output | 1 | First cycle of each data-enable pulse |

## Verification
The assertions check these properties on every cycle:
- the frame strobe coincides with an active vertical pulse;
- the line strobe coincides with data enable;
- every rising pulse is flagged as a pulse start;
- a finished train stays idle until a new frame;
- shadowed lengths hold between frame starts;
- a disabled generator shows its inactive levels.

Exact interval lengths, offsets, pulse counts and truncation at a frame boundary can only be shown by the bench scenarios. The same holds for timing changes that apply only from the next frame, and for polarity toggling. In those scenarios a timeline model predicts every output level cycle by cycle.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_ON   = 2'd2,
    PH_OFF  = 2'd3
  } train_phase_t;
endpackage

// File: rtl/stg_frame_ctrl.sv
module stg_frame_ctrl #(
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] dly_i,
  input  logic [LW-1:0] high_i,
  input  logic [LW-1:0] low_i,
  output logic          start_o,
  output logic          vs_q,
  output logic          fs_q
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic          act_q, act_n;
  logic          dwell_q, dwell_n;
  logic          hi_q, hi_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [LW-1:0] lo_q, lo_n;

  always_comb begin
    act_n   = act_q;
    dwell_n = dwell_q;
    hi_n    = hi_q;
    cnt_n   = cnt_q;
    lo_n    = lo_q;
    start_o = 1'b0;
    if (rst || !en) begin
      act_n   = 1'b0;
      dwell_n = 1'b0;
      hi_n    = 1'b0;
      cnt_n   = '0;
    end else if (!act_q) begin
      act_n = 1'b1;
      if (dly_i == '0) start_o = 1'b1;
      else begin
        dwell_n = 1'b1;
        cnt_n   = dly_i;
      end
    end else if (cnt_q == ONE) begin
      if (!hi_q) start_o = 1'b1;
      else begin
        hi_n  = 1'b0;
        cnt_n = lo_q;
      end
    end else begin
      cnt_n = cnt_q - ONE;
    end
    if (start_o) begin
      dwell_n = 1'b0;
      hi_n    = 1'b1;
      cnt_n   = (high_i == '0) ? ONE : high_i;
      lo_n    = (low_i == '0) ? ONE : low_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      dwell_q <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= '0;
      vs_q    <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      act_q   <= act_n;
      dwell_q <= dwell_n;
      hi_q    <= hi_n;
      cnt_q   <= cnt_n;
      lo_q    <= lo_n;
      vs_q    <= hi_n;
      fs_q    <= start_o;
    end
  end

  // R2: a frame strobe only ever appears with an active vertical pulse
  a_r2_strobe_in_vs: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> vs_q);

  // R8: the shadowed inactive length changes only on a frame start edge
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !start_o |=> $stable(lo_q));
endmodule

// File: rtl/stg_pulse_train.sv
module stg_pulse_train
  import stg_pkg::*;
#(
  parameter int LW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic [LW-1:0] lead_i,
  input  logic [SW-1:0] on_i,
  input  logic [SW-1:0] off_i,
  input  logic [SW-1:0] reps_i,
  output logic          pulse_q,
  output logic          beg_q
);
  localparam logic [LW-1:0] ONE  = LW'(1);
  localparam logic [SW-1:0] ONES = SW'(1);

  train_phase_t  ph_q, ph_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [SW-1:0] left_q, left_n;
  logic [SW-1:0] on_q, on_n, off_q, off_n;
  logic          beg;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    left_n = left_q;
    on_n   = on_q;
    off_n  = off_q;
    beg    = 1'b0;
    if (clr) begin
      ph_n   = PH_IDLE;
      cnt_n  = '0;
      left_n = '0;
    end else if (start) begin
      on_n   = (on_i == '0) ? ONES : on_i;
      off_n  = (off_i == '0) ? ONES : off_i;
      left_n = reps_i;
      if (lead_i != '0) begin
        ph_n  = PH_LEAD;
        cnt_n = lead_i;
      end else if (reps_i == '0) begin
        ph_n = PH_IDLE;
      end else begin
        ph_n  = PH_ON;
        cnt_n = LW'(on_n);
        beg   = 1'b1;
      end
    end else begin
      unique case (ph_q)
        PH_LEAD: begin
          if (cnt_q != ONE) cnt_n = cnt_q - ONE;
          else if (left_q == '0) ph_n = PH_IDLE;
          else begin
            ph_n  = PH_ON;
            cnt_n = LW'(on_q);
            beg   = 1'b1;
          end
        end
        PH_ON: begin
          if (cnt_q != ONE) cnt_n = cnt_q - ONE;
          else begin
            ph_n  = PH_OFF;
            cnt_n = LW'(off_q);
          end
        end
        PH_OFF: begin
          if (cnt_q != ONE) cnt_n = cnt_q - ONE;
          else if (left_q == ONES) begin
            ph_n   = PH_IDLE;
            left_n = '0;
          end else begin
            ph_n   = PH_ON;
            cnt_n  = LW'(on_q);
            left_n = left_q - ONES;
            beg    = 1'b1;
          end
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      on_q    <= ONES;
      off_q   <= ONES;
      pulse_q <= 1'b0;
      beg_q   <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      cnt_q   <= cnt_n;
      left_q  <= left_n;
      on_q    <= on_n;
      off_q   <= off_n;
      pulse_q <= (ph_n == PH_ON);
      beg_q   <= beg;
    end
  end

  // R5: a finished train stays idle and inactive until a new frame
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && !start && !clr) |=> (ph_q == PH_IDLE && !pulse_q));

  // R7: every rising pulse is flagged as a pulse start
  a_r7_rise_flagged: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> beg_q);
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int LW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] start_delay,
  input  logic [LW-1:0] vs_on_len,
  input  logic [LW-1:0] vs_off_len,
  input  logic [LW-1:0] hs_offset,
  input  logic [SW-1:0] hs_on_len,
  input  logic [SW-1:0] hs_off_len,
  input  logic [SW-1:0] hs_pulses,
  input  logic [LW-1:0] de_offset,
  input  logic [SW-1:0] de_on_len,
  input  logic [SW-1:0] de_off_len,
  input  logic [SW-1:0] de_pulses,
  input  logic          hs_invert,
  input  logic          vs_invert,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic          frame_start_o,
  output logic          line_start_o
);
  localparam int NTRAIN = 2;

  logic          frm_start, vs_act;
  logic          hinv_q, vinv_q;
  logic          clr;
  logic [LW-1:0] lead_a [NTRAIN];
  logic [SW-1:0] on_a   [NTRAIN];
  logic [SW-1:0] off_a  [NTRAIN];
  logic [SW-1:0] reps_a [NTRAIN];
  logic          pul_a  [NTRAIN];
  logic          beg_a  [NTRAIN];

  assign clr = rst || !en;

  stg_frame_ctrl #(.LW(LW)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .dly_i  (start_delay),
    .high_i (vs_on_len),
    .low_i  (vs_off_len),
    .start_o(frm_start),
    .vs_q   (vs_act),
    .fs_q   (frame_start_o)
  );

  assign lead_a[0] = hs_offset;
  assign on_a[0]   = hs_on_len;
  assign off_a[0]  = hs_off_len;
  assign reps_a[0] = hs_pulses;
  assign lead_a[1] = de_offset;
  assign on_a[1]   = de_on_len;
  assign off_a[1]  = de_off_len;
  assign reps_a[1] = de_pulses;

  for (genvar g = 0; g < NTRAIN; g++) begin : g_train
    stg_pulse_train #(.LW(LW), .SW(SW)) u_train (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .start  (frm_start),
      .lead_i (lead_a[g]),
      .on_i   (on_a[g]),
      .off_i  (off_a[g]),
      .reps_i (reps_a[g]),
      .pulse_q(pul_a[g]),
      .beg_q  (beg_a[g])
    );
  end

  always_ff @(posedge clk) begin
    hinv_q <= hs_invert;
    vinv_q <= vs_invert;
  end

  assign vs_o         = vs_act ^ vinv_q;
  assign hs_o         = pul_a[0] ^ hinv_q;
  assign de_o         = pul_a[1];
  assign line_start_o = beg_a[1];

  // R10: a disabled generator shows no enable or strobes on the next cycle
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de_o && !frame_start_o && !line_start_o));

  // R9: disabled vertical sync rests at the sampled inversion level
  a_r9_vs_rest: assert property (@(posedge clk) disable iff (rst)
    !en |=> (vs_o == $past(vs_invert)));

  // R7: the line strobe falls inside a data-enable pulse
  a_r7_ls_in_de: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> de_o);

  // R3: a horizontal pulse rise is always a flagged pulse start
  a_r3_hs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pul_a[0]) |-> beg_a[0]);
endmodule

// File: tb/sync_timing_gen_tb_top.sv
`timescale 1ns/1ps
module sync_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst, en;
  logic [23:0] start_delay, vs_on_len, vs_off_len, hs_offset, de_offset;
  logic [15:0] hs_on_len, hs_off_len, hs_pulses, de_on_len, de_off_len, de_pulses;
  logic        hs_invert, vs_invert;
  logic        vs_o, hs_o, de_o, frame_start_o, line_start_o;

  always #10 clk = ~clk;

  sync_timing_gen dut_i (
    .clk(clk), .rst(rst), .en(en),
    .start_delay(start_delay), .vs_on_len(vs_on_len), .vs_off_len(vs_off_len),
    .hs_offset(hs_offset), .hs_on_len(hs_on_len), .hs_off_len(hs_off_len),
    .hs_pulses(hs_pulses), .de_offset(de_offset), .de_on_len(de_on_len),
    .de_off_len(de_off_len), .de_pulses(de_pulses),
    .hs_invert(hs_invert), .vs_invert(vs_invert),
    .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o),
    .frame_start_o(frame_start_o), .line_start_o(line_start_o)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    started = 0, done = 0;

  // timeline reference model
  bit m_act = 0, m_infr = 0;
  int m_wait, m_t;
  int mH, mL, hL, hOn, hOff, hN, dL, dOn, dOff, dN;
  bit e_vs, e_hs, e_de, e_fs, e_ls;

  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit train(input int t, input int lead, input int on,
                               input int off, input int reps, output bit first);
    int u, per, k, ph;
    first = 0;
    if (t < lead) return 0;
    u = t - lead;
    per = on + off;
    k = u / per;
    if (k >= reps) return 0;
    ph = u % per;
    first = (ph == 0);
    return ph < on;
  endfunction

  task automatic new_frame();
    mH = atleast1(int'(vs_on_len));  mL = atleast1(int'(vs_off_len));
    hL = int'(hs_offset); hOn = atleast1(int'(hs_on_len));
    hOff = atleast1(int'(hs_off_len)); hN = int'(hs_pulses);
    dL = int'(de_offset); dOn = atleast1(int'(de_on_len));
    dOff = atleast1(int'(de_off_len)); dN = int'(de_pulses);
    m_t = 0;
    m_infr = 1;
  endtask

  always @(posedge clk) begin
    bit hfirst, dfirst, hs_i, de_i;
    if (rst || !en) begin
      m_act = 0; m_infr = 0;
    end else if (!m_act) begin
      m_act = 1;
      if (start_delay == 0) new_frame();
      else begin m_infr = 0; m_wait = int'(start_delay); end
    end else if (!m_infr) begin
      m_wait--;
      if (m_wait == 0) new_frame();
    end else begin
      m_t++;
      if (m_t == mH + mL) new_frame();
    end
    hs_i = 0; de_i = 0; dfirst = 0;
    if (m_infr) begin
      hs_i = train(m_t, hL, hOn, hOff, hN, hfirst);
      de_i = train(m_t, dL, dOn, dOff, dN, dfirst);
    end
    e_vs = (m_infr && m_t < mH) ^ vs_invert;
    e_hs = hs_i ^ hs_invert;
    e_de = de_i;
    e_fs = m_infr && m_t == 0;
    e_ls = de_i && dfirst;
    started = 1;
  end

  task automatic chk(input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, sig, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("vs_o", vs_o, e_vs);
      chk("hs_o", hs_o, e_hs);
      chk("de_o", de_o, e_de);
      chk("frame_start_o", frame_start_o, e_fs);
      chk("line_start_o", line_start_o, e_ls);
    end
  end

  task automatic cfg(input int dly, input int vh, input int vl,
                     input int hl, input int hon, input int hoff, input int hn,
                     input int dl, input int don, input int doff, input int dn);
    start_delay = 24'(dly); vs_on_len = 24'(vh); vs_off_len = 24'(vl);
    hs_offset = 24'(hl); hs_on_len = 16'(hon); hs_off_len = 16'(hoff); hs_pulses = 16'(hn);
    de_offset = 24'(dl); de_on_len = 16'(don); de_off_len = 16'(doff); de_pulses = 16'(dn);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1; en = 0; hs_invert = 0; vs_invert = 0;
    cfg(3, 4, 30, 2, 3, 2, 5, 5, 4, 3, 3);
    cur_req = "R10";
    run(4);
    // explicit reset state check (R10)
    checks++;
    if (vs_o !== 1'b0 || hs_o !== 1'b0 || de_o !== 1'b0 || frame_start_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset state: actual %b%b%b%b expected 0000", vs_o, hs_o, de_o, frame_start_o);
    end
    rst = 0; run(2);
    // R1 start delay, R2/R3/R4 basic frame, R5 idle after trains, R7 strobes
    cur_req = "R1/R2/R3/R4/R5/R7";
    en = 1; run(110);
    // R5 truncation by a new frame, R6 zero pulse count
    cur_req = "R5/R6";
    cfg(0, 2, 20, 1, 3, 2, 10, 4, 2, 1, 0);
    run(90);
    // R2/R3/R4 zero lengths count as one, zero offsets
    cur_req = "R2/R3/R4";
    cfg(0, 0, 0, 0, 0, 0, 3, 0, 1, 1, 2);
    run(40);
    cfg(0, 3, 17, 0, 1, 1, 4, 0, 2, 2, 3);
    run(60);
    // R8 mid-frame changes apply only at the next frame
    cur_req = "R8";
    cfg(0, 5, 40, 3, 4, 4, 4, 6, 5, 2, 4);
    run(50);
    @(negedge clk);
    cfg(9, 2, 25, 1, 2, 1, 6, 2, 3, 3, 2);
    run(20);
    cfg(9, 6, 31, 4, 2, 5, 3, 1, 6, 1, 3);
    run(120);
    // R9 polarity toggling
    cur_req = "R9";
    for (int i = 0; i < 12; i++) begin
      hs_invert = i[0]; vs_invert = i[1];
      run(7);
    end
    // R10 disable mid-frame, then R1 re-enable with new delay
    cur_req = "R10";
    run(13);
    en = 0; run(6);
    cur_req = "R1";
    cfg(5, 3, 12, 2, 2, 2, 3, 3, 2, 1, 2);
    en = 1; run(70);
    cfg(0, 3, 12, 2, 2, 2, 3, 3, 2, 1, 2);
    en = 0; run(3);
    en = 1; run(40);
    cur_req = "R10";
    rst = 1; run(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule